// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block runs the external memory cycles of a small 8-bit controller core. The core hands it one request at a time. A request is a code fetch with a 16-bit address, a data read or write with a 16-bit address, or a data read or write with an 8-bit address. For a code fetch the block first decides whether the address is served by internal program memory. If so, it answers on the next cycle without touching the bus. Otherwise it runs a fixed multi-phase cycle on a bus where the low address byte and the data byte share one set of pins.

Each external cycle has a fixed order. An address-latch-enable pulse comes first, while the low address byte is on the shared pins. The low byte is still held there as that pulse falls. Then one of three active-low strobes asserts for two cycles: the program strobe for fetches, or the separate read and write strobes for data. After the strobe releases there is a completion cycle, which carries a done pulse and the read byte back to the core.

The high pins carry the upper address byte during 16-bit accesses. During 8-bit accesses and between cycles they show the core's high-port register, which allows paging. The block also pulses a request that loads all ones into the core's low-port register on every external access.

Top module: `xbus_seq`

## Requirements
- R1: While reset is held, `ale` is 0, `psenN`, `rdN` and `wrN` are 1, `busLoOe` is 0, `rspDone` is 0 and `reqReady` is 1.
- R2: A fetch (`reqKind` 0) with `extAccessN` = 1 and an address below `INT_ROM_SIZE` produces `rspDone` = 1 and `rspInternal` = 1 in the cycle after acceptance. There is no `ale` pulse, no strobe, no `busLoOe` and no `loRegForceFf`.
- R3: A fetch goes to the bus when `extAccessN` is 0 or the address is at least `INT_ROM_SIZE`. It uses only `psenN` as its strobe, and the full 16-bit address appears on the bus. At most one strobe is ever low.
- R4: An external cycle runs as follows after the accepting edge. Cycle 1 has `ale` = 1. Cycle 2 has `ale` = 0 and all strobes high. Cycles 3 and 4 have the selected strobe low. Cycle 5 has all strobes high and `rspDone` = 1. The low address byte is on `busLoOut` with `busLoOe` = 1 in cycles 1 and 2.
- R5: In a 16-bit access (`reqKind` 0 or 1), `busHiOut` equals the upper address byte for all five cycles. In an 8-bit access (`reqKind` 2 or 3), it equals `hiPortReg` for all five cycles.
- R6: When no external cycle is in progress, `busHiOut` equals `hiPortReg`.
- R7: In a data write, `wrN` is low for exactly two cycles. `busLoOut` carries the write byte with `busLoOe` = 1 from the first strobe cycle through the completion cycle.
- R8: In a data read or external fetch, `busLoOe` is 0 while the strobe is low. `busLoIn` is sampled at the end of the second strobe cycle. `rspData` shows that byte from the completion cycle until the next read completes.
- R9: `loRegForceFf` pulses for one cycle, in the `ale` cycle, for every external access, and never for an internal fetch.
- R10: A request presented in the completion cycle is accepted at once. Its `ale` cycle follows directly, and `busHiOut` goes straight to the new address with no `hiPortReg` value in between.
- R11: `reqReady` is 0 during cycles 1 to 4 of an external cycle. A request raised then is ignored, and no extra cycle follows the current one.
- R12: A fetch ignores `reqWrite`. `psenN` is the strobe, `wrN` stays high, and the shared pins are not driven while the strobe is low.
- R13: With `INT_ROM_SIZE` = 0, every fetch goes to the bus whatever `extAccessN` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 2 | 0 fetch, 1 data with 16-bit address, 2 or 3 data with 8-bit address |
| reqWrite | input | 1 | Data request is a write |
| reqAddr | input | ADDR_W | Request address; 8-bit accesses use the low byte |
| reqWdata | input | DATA_W | Write byte |
| reqReady | output | 1 | A request can be taken this cycle |
| extAccessN | input | 1 | Active low: all fetches external |
| hiPortReg | input | ADDR_W-DATA_W | Current high-port register value |
| loRegForceFf | output | 1 | Load all ones into the low-port register |
| busLoIn | input | DATA_W | Shared pins, input side |
| busLoOut | output | DATA_W | Shared pins, output side |
| busLoOe | output | 1 | Shared pins output enable |
| busHiOut | output | ADDR_W-DATA_W | High pins |
| ale | output | 1 | Address latch enable |
| psenN | output | 1 | Program strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| rspDone | output | 1 | Request complete |
| rspInternal | output | 1 | Completed fetch belongs to internal memory |
| rspData | output | DATA_W | Last byte read from the bus |

## Verification
The completion cycle of one access and the acceptance of the next can fall in the same cycle. The bench provokes this by raising a new request during the done cycle of a write and chaining a read and a fetch behind it. It then checks that the next `ale` cycle follows at once and that `busHiOut` moves from one address to the next without showing `hiPortReg`. It also checks that the scoreboard receives each completion in order. A second overlap is a read sample next to a done pulse. The bench changes `busLoIn` just before and just after the sampling edge, so a sample taken one cycle early or late returns the wrong byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // request kinds: bit 1 set selects the 8-bit address form
  typedef enum logic [1:0] {
    KIND_FETCH  = 2'd0,
    KIND_DATA16 = 2'd1,
    KIND_DATA8  = 2'd2,
    KIND_DATA8B = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_STRB  = 3'd3,
    PH_DATA  = 3'd4,
    PH_HOLD  = 3'd5,
    PH_INT   = 3'd6
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;    // take the presented request
    logic ale;        // address latch pulse
    logic driveAddr;  // low address byte on the shared pins
    logic busPhase;   // strobe window plus completion cycle
    logic strobeOn;   // selected strobe low
    logic sample;     // capture read byte at end of this cycle
    logic done;       // completion pulse
    logic internal;   // internal fetch completion
    logic extCycle;   // high pins in address mode
    logic forceLo;    // low-port register load request
  } dpCtl_t;

endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned INT_ROM_SIZE = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              extAccessN,
  output logic              reqReady,
  output dpCtl_t            ctl
);

  phase_e ph;
  phase_e phNext;
  logic   fetchExt;
  logic   accept;
  logic   isFetch;

  // internal or external program memory decision
  generate
    if (INT_ROM_SIZE == 0) begin : g_noRom
      logic unusedIn;
      assign unusedIn = extAccessN ^ (^reqAddr);
      assign fetchExt = 1'b1;
    end else begin : g_rom
      assign fetchExt = !extAccessN || (32'(reqAddr) >= INT_ROM_SIZE);
    end
  endgenerate

  assign isFetch  = (reqKind == KIND_FETCH);
  assign reqReady = (ph == PH_IDLE) || (ph == PH_HOLD) || (ph == PH_INT);
  assign accept   = reqValid && reqReady;

  always_comb begin
    phNext = ph;
    unique case (ph)
      PH_IDLE, PH_HOLD, PH_INT: begin
        if (accept) phNext = (isFetch && !fetchExt) ? PH_INT : PH_ADDR;
        else        phNext = PH_IDLE;
      end
      PH_ADDR:  phNext = PH_LATCH;
      PH_LATCH: phNext = PH_STRB;
      PH_STRB:  phNext = PH_DATA;
      PH_DATA:  phNext = PH_HOLD;
      default:  phNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ph <= PH_IDLE;
    else       ph <= phNext;
  end

  always_comb begin
    ctl           = '0;
    ctl.capture   = accept;
    ctl.ale       = (ph == PH_ADDR);
    ctl.forceLo   = (ph == PH_ADDR);
    ctl.driveAddr = (ph == PH_ADDR) || (ph == PH_LATCH);
    ctl.strobeOn  = (ph == PH_STRB) || (ph == PH_DATA);
    ctl.busPhase  = (ph == PH_STRB) || (ph == PH_DATA) || (ph == PH_HOLD);
    ctl.sample    = (ph == PH_DATA);
    ctl.done      = (ph == PH_HOLD) || (ph == PH_INT);
    ctl.internal  = (ph == PH_INT);
    ctl.extCycle  = (ph == PH_ADDR) || (ph == PH_LATCH) || ctl.busPhase;
  end

  // R4: the strobe window is always two cycles long
  assert_strobe_pair_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_STRB) |=> (ph == PH_DATA));

  // R11: busy phases never accept a request
  assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_LATCH) |=> !reqReady);

endmodule

// File: rtl/xbus_dp.sv
module xbus_dp
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [HI_W-1:0]   hiPortReg,
  input  logic [DATA_W-1:0] busLoIn,
  output logic [DATA_W-1:0] busLoOut,
  output logic              busLoOe,
  output logic [HI_W-1:0]   busHiOut,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              loRegForceFf,
  output logic              rspDone,
  output logic              rspInternal,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWdata;
  logic              curFetch;
  logic              curWrite;
  logic              curShort;
  logic [DATA_W-1:0] rdBuf;
  logic              driveWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWdata <= '0;
      curFetch <= 1'b0;
      curWrite <= 1'b0;
      curShort <= 1'b0;
    end else if (ctl.capture) begin
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
      curFetch <= (reqKind == KIND_FETCH);
      curWrite <= reqWrite && (reqKind != KIND_FETCH);
      curShort <= reqKind[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        rdBuf <= '0;
    else if (ctl.sample && !curWrite) rdBuf <= busLoIn;
  end

  assign driveWr  = ctl.busPhase && curWrite;
  assign busLoOe  = ctl.driveAddr || driveWr;
  assign busLoOut = ctl.driveAddr ? curAddr[DATA_W-1:0] :
                    (driveWr ? curWdata : '0);
  assign busHiOut = (ctl.extCycle && !curShort) ? curAddr[ADDR_W-1:DATA_W] : hiPortReg;

  assign psenN = !(ctl.strobeOn && curFetch);
  assign rdN   = !(ctl.strobeOn && !curFetch && !curWrite);
  assign wrN   = !(ctl.strobeOn && curWrite);

  assign ale          = ctl.ale;
  assign loRegForceFf = ctl.forceLo;
  assign rspDone      = ctl.done;
  assign rspInternal  = ctl.internal;
  assign rspData      = rdBuf;

  // R3: never more than one strobe low
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones({~psenN, ~rdN, ~wrN}) <= 1);

  // R7: write byte driven while the write strobe is low
  assert_wr_drives_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busLoOe);

  // R7: write byte still driven after the write strobe rises
  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrN) |-> busLoOe);

  // R7: write strobe lasts two cycles
  assert_wr_two_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wrN) |=> !wrN);

  // R8: shared pins released during a read strobe
  assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !psenN) |-> !busLoOe);

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned INT_ROM_SIZE = 4096,
  localparam int unsigned HI_W        = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic              extAccessN,
  input  logic [HI_W-1:0]   hiPortReg,
  output logic              loRegForceFf,
  input  logic [DATA_W-1:0] busLoIn,
  output logic [DATA_W-1:0] busLoOut,
  output logic              busLoOe,
  output logic [HI_W-1:0]   busHiOut,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              rspDone,
  output logic              rspInternal,
  output logic [DATA_W-1:0] rspData
);

  dpCtl_t ctl;

  xbus_ctrl #(.ADDR_W(ADDR_W), .INT_ROM_SIZE(INT_ROM_SIZE)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .extAccessN(extAccessN), .reqReady(reqReady), .ctl(ctl)
  );

  xbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .hiPortReg(hiPortReg),
    .busLoIn(busLoIn), .busLoOut(busLoOut), .busLoOe(busLoOe),
    .busHiOut(busHiOut), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .loRegForceFf(loRegForceFf), .rspDone(rspDone),
    .rspInternal(rspInternal), .rspData(rspData)
  );

  // R4: address latch pulse is a single cycle followed by a quiet cycle
  assert_ale_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> (!ale && psenN && rdN && wrN && busLoOe));

  // R9: low-port register load accompanies every address latch pulse
  assert_ale_force_R9: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> loRegForceFf);

  // R4: completion cycle has all strobes released
  assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (psenN && rdN && wrN));

  // R2: internal completion leaves the bus alone
  assert_int_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspInternal |-> (!busLoOe && !loRegForceFf && psenN));

endmodule

// File: tb/test_xbus_seq.sv
`timescale 1ns/1ps
module test_xbus_seq;

  localparam int unsigned ROM = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = 16'h0;
  logic [7:0]  reqWdata = 8'h0;
  logic        extAccessN = 1'b1;
  logic [7:0]  hiPortReg = 8'hA5;
  logic [7:0]  busLoIn = 8'h00;

  logic       reqReady, loRegForceFf, busLoOe, ale, psenN, rdN, wrN, rspDone, rspInternal;
  logic [7:0] busLoOut, busHiOut, rspData;
  logic       reqReadyZ, loRegForceFfZ, busLoOeZ, aleZ, psenNZ, rdNZ, wrNZ, rspDoneZ, rspInternalZ;
  logic [7:0] busLoOutZ, busHiOutZ, rspDataZ;

  always #2.5 clk = ~clk;

  xbus_seq #(.INT_ROM_SIZE(ROM)) i_xbus_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .extAccessN(extAccessN),
    .hiPortReg(hiPortReg), .loRegForceFf(loRegForceFf), .busLoIn(busLoIn),
    .busLoOut(busLoOut), .busLoOe(busLoOe), .busHiOut(busHiOut), .ale(ale),
    .psenN(psenN), .rdN(rdN), .wrN(wrN), .rspDone(rspDone),
    .rspInternal(rspInternal), .rspData(rspData)
  );

  // romless variant for R13
  xbus_seq #(.INT_ROM_SIZE(0)) i_xbus_seq_norom (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReadyZ), .extAccessN(extAccessN),
    .hiPortReg(hiPortReg), .loRegForceFf(loRegForceFfZ), .busLoIn(busLoIn),
    .busLoOut(busLoOutZ), .busLoOe(busLoOeZ), .busHiOut(busHiOutZ), .ale(aleZ),
    .psenN(psenNZ), .rdN(rdNZ), .wrN(wrNZ), .rspDone(rspDoneZ),
    .rspInternal(rspInternalZ), .rspData(rspDataZ)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  typedef struct {
    logic       internal;
    logic       chkData;
    logic [7:0] data;
  } exp_t;
  exp_t sbq[$];

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    exp_t e;
    if (rstN && rspDone && !finished) begin
      if (sbq.size() == 0) begin
        nChecks++; nFail++;
        $display("FAIL R4 unexpected done: actual 1 expected 0");
      end else begin
        e = sbq.pop_front();
        check("R2", "rspInternal", 32'(rspInternal), 32'(e.internal));
        if (e.chkData) check("R8", "rspData", 32'(rspData), 32'(e.data));
      end
    end
  end

  task automatic extAccess(input logic [1:0] kind, input logic wr, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] rdv, input logic poke);
    logic       isFetch;
    logic       isWr;
    logic [7:0] expHi;
    logic [2:0] expStrb;
    isFetch = (kind == 2'd0);
    isWr    = wr && !isFetch;
    expHi   = kind[1] ? hiPortReg : addr[15:8];
    expStrb = {!isFetch, !(!isFetch && !isWr), !isWr};
    sbq.push_back('{1'b0, !isWr, rdv});
    reqValid = 1'b1; reqKind = kind; reqWrite = wr; reqAddr = addr; reqWdata = wd;
    busLoIn = ~rdv;
    @(negedge clk); // ale cycle
    reqValid = poke;
    reqAddr  = addr ^ 16'h5A5A;
    check("R4", "ale", 32'(ale), 32'd1);
    check("R4", "lo addr", 32'({busLoOe, busLoOut}), 32'({1'b1, addr[7:0]}));
    check("R5", "hi ale", 32'(busHiOut), 32'(expHi));
    check("R9", "force", 32'(loRegForceFf), 32'd1);
    check("R11", "ready busy", 32'(reqReady), 32'd0);
    @(negedge clk); // latch cycle
    reqValid = 1'b0;
    check("R4", "ale low", 32'(ale), 32'd0);
    check("R4", "lo addr hold", 32'({busLoOe, busLoOut}), 32'({1'b1, addr[7:0]}));
    check("R4", "strobes idle", 32'({psenN, rdN, wrN}), 32'd7);
    check("R9", "force once", 32'(loRegForceFf), 32'd0);
    check("R5", "hi latch", 32'(busHiOut), 32'(expHi));
    @(negedge clk); // first strobe cycle
    check(isFetch ? "R3" : "R4", "strobe1", 32'({psenN, rdN, wrN}), 32'(expStrb));
    check(isWr ? "R7" : "R12", "oe strobe1", 32'(busLoOe), 32'(isWr));
    if (isWr) check("R7", "wdata1", 32'(busLoOut), 32'(wd));
    check("R5", "hi strobe1", 32'(busHiOut), 32'(expHi));
    @(negedge clk); // second strobe cycle
    check("R4", "strobe2", 32'({psenN, rdN, wrN}), 32'(expStrb));
    check("R8", "oe strobe2", 32'(busLoOe), 32'(isWr));
    busLoIn = rdv;
    @(negedge clk); // completion cycle
    busLoIn = rdv ^ 8'h81;
    check("R4", "done", 32'(rspDone), 32'd1);
    check("R4", "strobes released", 32'({psenN, rdN, wrN}), 32'd7);
    check("R5", "hi done", 32'(busHiOut), 32'(expHi));
    if (isWr) check("R7", "wdata held", 32'({busLoOe, busLoOut}), 32'({1'b1, wd}));
  endtask

  task automatic idleCheck(input string tag, input logic [7:0] lastRd, input logic chkRd);
    @(negedge clk);
    check(tag, "idle ale", 32'(ale), 32'd0);
    check("R6", "idle hi", 32'(busHiOut), 32'(hiPortReg));
    check("R11", "idle ready", 32'(reqReady), 32'd1);
    if (chkRd) check("R8", "rspData held", 32'(rspData), 32'(lastRd));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "ale", 32'(ale), 32'd0);
    check("R1", "strobes", 32'({psenN, rdN, wrN}), 32'd7);
    check("R1", "oe/done/ready", 32'({busLoOe, rspDone, reqReady}), 32'b001);
    rstN = 1'b1;
    @(negedge clk);

    // R2 boundary below size, plus R13 romless variant
    sbq.push_back('{1'b1, 1'b0, 8'h00});
    reqValid = 1'b1; reqKind = 2'd0; reqWrite = 1'b0; reqAddr = 16'h0FFF; extAccessN = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2", "int done", 32'({rspDone, rspInternal}), 32'b11);
    check("R2", "int quiet", 32'({ale, loRegForceFf, busLoOe, psenN}), 32'b0001);
    check("R13", "romless ale", 32'(aleZ), 32'd1);
    repeat (6) @(negedge clk);
    check("R6", "hi idle", 32'(busHiOut), 32'(hiPortReg));

    // R3 fetch at exactly the size limit
    extAccess(2'd0, 1'b0, 16'h1000, 8'h00, 8'h6E, 1'b0);
    idleCheck("R3", 8'h6E, 1'b1);
    // R3 forced external by extAccessN, R12 reqWrite ignored
    extAccessN = 1'b0;
    extAccess(2'd0, 1'b1, 16'h0123, 8'hEE, 8'h3B, 1'b0);
    extAccessN = 1'b1;
    idleCheck("R12", 8'h3B, 1'b1);
    check("R12", "no write strobe", 32'(wrN), 32'd1);
    // R5 16-bit data read
    extAccess(2'd1, 1'b0, 16'h7C42, 8'h00, 8'hD4, 1'b0);
    idleCheck("R5", 8'hD4, 1'b1);
    // R5 8-bit read with paging, R11 poke while busy
    hiPortReg = 8'h3E;
    extAccess(2'd2, 1'b0, 16'h0019, 8'h00, 8'h91, 1'b1);
    idleCheck("R11", 8'h91, 1'b1);
    // R7 8-bit write
    extAccess(2'd3, 1'b1, 16'h00C7, 8'h5D, 8'h00, 1'b0);
    idleCheck("R7", 8'h91, 1'b1);
    // R10 chained: write, read, fetch with no idle cycle between
    extAccess(2'd1, 1'b1, 16'h9A10, 8'hC3, 8'h00, 1'b0);
    extAccess(2'd1, 1'b0, 16'hB220, 8'h00, 8'h4F, 1'b0);
    extAccess(2'd0, 1'b0, 16'hE001, 8'h00, 8'h17, 1'b0);
    idleCheck("R10", 8'h17, 1'b1);
    // R9 an internal fetch must not pulse the force request
    sbq.push_back('{1'b1, 1'b0, 8'h00});
    reqValid = 1'b1; reqKind = 2'd0; reqAddr = 16'h0040;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9", "no force internal", 32'(loRegForceFf), 32'd0);
    idleCheck("R2", 8'h17, 1'b1);
    check("R4", "scoreboard drained", 32'(sbq.size()), 32'd0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule